// File: doc/BRIEF.md
# Parallel Flash Write-Command Emulator

This block stands in front of a small on-chip byte store and makes it answer to the byte-wide write commands of a classic parallel NOR flash. Every write strobe, with its address and data byte, is fed to a sequence tracker. The tracker accepts an unlock handshake at two fixed command addresses and then one operation byte. The operation can arm a one-shot byte program, begin a second unlock that leads to a sector or whole-array erase, or switch an identification overlay on or off.

Programming can only clear bits: the new byte is ANDed into the stored one. Both erase kinds run as a sweep that writes 0xFF one location per clock. While a sweep runs, `busy` is high and all writes are dropped. While the identification overlay is on, reads of locations 0 and 1 return a vendor code and a size-dependent device code. The stored bytes stay intact underneath and show again once the overlay is off. Reads have one cycle of latency.

Top module: `flash_cmd_emu`

## Requirements
- R1: While `rst_n` is low and after it is released, `seq_state` is 0, `busy` is 0, `rd_data` is 0x00 and the identification overlay is off.
- R2: A write is a command write only when `wr_addr[14:0]` equals 0x5555 (the "A" address) or 0x2AAA (the "B" address), and `wr_addr[ADDR_W-1:15]` is either zero or equal to `cmd_bank`.
- R3: `seq_state` encodes the step reached: 0 idle, 1 after 0xAA at A, 2 after 0x55 at B, 3 program armed, 4 erase set up (after 0x80 at A in step 2), 5 after a second 0xAA at A, 6 after a second 0x55 at B. Writing 0xA0 at A in step 2 gives step 3.
- R4: In step 3 the next write, to any address, stores (old AND data) at `wr_addr[ARR_W-1:0]`, and the state returns to 0.
- R5: A write that does not match the expected address and data for the current step returns the state to 0 and leaves the stored bytes unchanged.
- R6: In step 6, writing 0x30 to any address erases the aligned block of 2^SECT_W bytes that contains that address. `busy` is high for exactly 2^SECT_W cycles, starting on the cycle after the write.
- R7: In step 6, writing 0x10 at A erases every location. `busy` is high for exactly 2^ARR_W cycles. Afterwards every location reads 0xFF.
- R8: While `busy` is high, writes have no effect on the state, the stored bytes or the overlay, and `seq_state` stays 0.
- R9: A read with `rd_en` high updates `rd_data` on the next rising edge. `rd_data` then holds until the next read.
- R10: Writing 0x90 at A in step 2 turns the overlay on. While it is on, location 0 reads 0xBF and location 1 reads the device code. Other locations, and writes, behave as normal. The bytes stored at locations 0 and 1 are kept.
- R11: The device code depends on `size_sel`: 1 gives 0xB5, 2 gives 0xB6, 3 gives 0xB7. With `size_sel` = 0 the 0x90 command is ignored.
- R12: While the overlay is on, a single write of 0xF0 to any address in step 0 turns it off. So does 0xF0 at A in step 2. A 0xF0 written in any other step only resets the state and leaves the overlay on.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe, one write per cycle |
| wr_addr | input | ADDR_W | Write byte address |
| wr_data | input | 8 | Write data byte |
| rd_en | input | 1 | Read request |
| rd_addr | input | ARR_W | Read byte address |
| rd_data | output | 8 | Read data, valid one cycle after `rd_en` |
| size_sel | input | 2 | Static size code that selects the device code |
| cmd_bank | input | ADDR_W-15 | Alternate upper address bits accepted on command writes |
| busy | output | 1 | Erase sweep in progress |
| seq_state | output | 3 | Current command step |

## Verification
The bench first fills the array by programming every location twice with two different patterns. Any design that overwrites instead of ANDing shows a mismatch at once. The aligned sector erase is started from an address in the middle of the sector, and the bench counts the exact `busy` length and checks the bytes just outside the sector. A wrong base, a wrong width or an off-by-one in the sweep therefore corrupts or misses a neighbour.

For the overlay, the bench programs location 0 while the overlay is on and then sends 0xF0 from a non-idle step. This exposes both a design that lets the overlay bytes reach storage and one that exits the overlay too eagerly. It also sends upper address bits that are nonzero but not the bank value, which a design that ignores those bits would wrongly accept.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_UNL1 = 3'd1,
    ST_UNL2 = 3'd2,
    ST_PROG = 3'd3,
    ST_ERS1 = 3'd4,
    ST_ERS2 = 3'd5,
    ST_ERS3 = 3'd6
  } seq_t;

  localparam logic [14:0] CMD_ADDR_A = 15'h5555;
  localparam logic [14:0] CMD_ADDR_B = 15'h2AAA;
  localparam logic [7:0]  KEY_FIRST  = 8'hAA;
  localparam logic [7:0]  KEY_SECOND = 8'h55;
  localparam logic [7:0]  OP_PROGRAM = 8'hA0;
  localparam logic [7:0]  OP_ERASE   = 8'h80;
  localparam logic [7:0]  OP_ID_ON   = 8'h90;
  localparam logic [7:0]  OP_ID_OFF  = 8'hF0;
  localparam logic [7:0]  OP_SECTOR  = 8'h30;
  localparam logic [7:0]  OP_CHIP    = 8'h10;
  localparam logic [7:0]  VENDOR_CODE = 8'hBF;
  localparam logic [7:0]  ERASED_BYTE = 8'hFF;

  function automatic logic [7:0] device_code(input logic [1:0] sel);
    case (sel)
      2'd1:    device_code = 8'hB5;
      2'd2:    device_code = 8'hB6;
      2'd3:    device_code = 8'hB7;
      default: device_code = 8'h00;
    endcase
  endfunction

endpackage

// File: rtl/flash_seq.sv
module flash_seq
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W = 19
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_go,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic [ADDR_W-16:0] cmd_bank,
  input  logic              id_allowed,
  output seq_t              state_q,
  output logic              id_mode,
  output logic              prog_fire,
  output logic              sect_fire,
  output logic              chip_fire
);

  localparam int HI_W = ADDR_W - 15;

  logic [HI_W-1:0] hi_bits;
  logic            hi_ok;
  logic            hit_a;
  logic            hit_b;
  seq_t            state_d;
  logic            id_d;

  assign hi_bits = wr_addr[ADDR_W-1:15];
  assign hi_ok   = (hi_bits == '0) || (hi_bits == cmd_bank);
  assign hit_a   = hi_ok && (wr_addr[14:0] == CMD_ADDR_A);
  assign hit_b   = hi_ok && (wr_addr[14:0] == CMD_ADDR_B);

  always_comb begin
    state_d   = state_q;
    id_d      = id_mode;
    prog_fire = 1'b0;
    sect_fire = 1'b0;
    chip_fire = 1'b0;
    if (wr_go) begin
      state_d = ST_IDLE;
      if (id_mode && (state_q == ST_IDLE) && (wr_data == OP_ID_OFF)) begin
        id_d = 1'b0;
      end else begin
        case (state_q)
          ST_IDLE: if (hit_a && wr_data == KEY_FIRST)  state_d = ST_UNL1;
          ST_UNL1: if (hit_b && wr_data == KEY_SECOND) state_d = ST_UNL2;
          ST_UNL2: begin
            if (hit_a) begin
              case (wr_data)
                OP_PROGRAM: state_d = ST_PROG;
                OP_ERASE:   state_d = ST_ERS1;
                OP_ID_ON:   if (id_allowed) id_d = 1'b1;
                OP_ID_OFF:  id_d = 1'b0;
                default:    ;
              endcase
            end
          end
          ST_PROG: prog_fire = 1'b1;
          ST_ERS1: if (hit_a && wr_data == KEY_FIRST)  state_d = ST_ERS2;
          ST_ERS2: if (hit_b && wr_data == KEY_SECOND) state_d = ST_ERS3;
          ST_ERS3: begin
            if (wr_data == OP_SECTOR)           sect_fire = 1'b1;
            else if (hit_a && wr_data == OP_CHIP) chip_fire = 1'b1;
          end
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      id_mode <= 1'b0;
    end else if (wr_go) begin
      state_q <= state_d;
      id_mode <= id_d;
    end
  end

endmodule

// File: rtl/flash_sweep.sv
module flash_sweep #(
  parameter int ARR_W  = 13,
  parameter int SECT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sect_start,
  input  logic             chip_start,
  input  logic [ARR_W-1:0] start_addr,
  output logic             busy,
  output logic [ARR_W-1:0] sw_addr
);

  localparam logic [ARR_W-1:0] SECT_MASK = {{(ARR_W-SECT_W){1'b0}}, {SECT_W{1'b1}}};

  logic             chip_q;
  logic             busy_d;
  logic             chip_d;
  logic [ARR_W-1:0] addr_d;
  logic             last;

  assign last = chip_q ? (&sw_addr) : ((sw_addr & SECT_MASK) == SECT_MASK);

  always_comb begin
    busy_d = busy;
    chip_d = chip_q;
    addr_d = sw_addr;
    if (sect_start || chip_start) begin
      busy_d = 1'b1;
      chip_d = chip_start;
      addr_d = chip_start ? '0 : (start_addr & ~SECT_MASK);
    end else if (busy) begin
      addr_d = sw_addr + 1'b1;
      if (last) busy_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      chip_q  <= 1'b0;
      sw_addr <= '0;
    end else begin
      busy    <= busy_d;
      chip_q  <= chip_d;
      sw_addr <= addr_d;
    end
  end

endmodule

// File: rtl/flash_array.sv
module flash_array
  import flash_cmd_pkg::*;
#(
  parameter int ARR_W = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [ARR_W-1:0] waddr,
  input  logic [7:0]       wdata,
  output logic [7:0]       old_data,
  input  logic             rd_en,
  input  logic [ARR_W-1:0] rd_addr,
  input  logic             id_mode,
  input  logic [7:0]       dev_code,
  output logic [7:0]       rd_data
);

  localparam int DEPTH = 1 << ARR_W;

  logic [7:0] mem [DEPTH];
  logic [7:0] rd_val;

  assign old_data = mem[waddr];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_comb begin
    rd_val = mem[rd_addr];
    if (id_mode && rd_addr == '0)               rd_val = VENDOR_CODE;
    else if (id_mode && rd_addr == ARR_W'(1))   rd_val = dev_code;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rd_data <= 8'h00;
    else if (rd_en) rd_data <= rd_val;
  end

endmodule

// File: rtl/flash_cmd_emu.sv
module flash_cmd_emu
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W = 19,
  parameter int ARR_W  = 13,
  parameter int SECT_W = 12
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [ADDR_W-1:0]  wr_addr,
  input  logic [7:0]         wr_data,
  input  logic               rd_en,
  input  logic [ARR_W-1:0]   rd_addr,
  output logic [7:0]         rd_data,
  input  logic [1:0]         size_sel,
  input  logic [ADDR_W-16:0] cmd_bank,
  output logic               busy,
  output logic [2:0]         seq_state
);

  seq_t             state_q;
  logic             id_mode;
  logic             prog_fire;
  logic             sect_fire;
  logic             chip_fire;
  logic             wr_go;
  logic [7:0]       dev_code;
  logic [ARR_W-1:0] sw_addr;
  logic [ARR_W-1:0] local_addr;
  logic             mem_we;
  logic [ARR_W-1:0] mem_addr;
  logic [7:0]       mem_wdata;
  logic [7:0]       old_data;

  assign dev_code   = device_code(size_sel);
  assign wr_go      = wr_en && !busy;
  assign local_addr = wr_addr[ARR_W-1:0];
  assign seq_state  = state_q;

  flash_seq #(.ADDR_W(ADDR_W)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_go      (wr_go),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .cmd_bank   (cmd_bank),
    .id_allowed (dev_code != 8'h00),
    .state_q    (state_q),
    .id_mode    (id_mode),
    .prog_fire  (prog_fire),
    .sect_fire  (sect_fire),
    .chip_fire  (chip_fire)
  );

  flash_sweep #(.ARR_W(ARR_W), .SECT_W(SECT_W)) u_sweep (
    .clk        (clk),
    .rst_n      (rst_n),
    .sect_start (sect_fire),
    .chip_start (chip_fire),
    .start_addr (local_addr),
    .busy       (busy),
    .sw_addr    (sw_addr)
  );

  always_comb begin
    mem_we    = busy || prog_fire;
    mem_addr  = busy ? sw_addr : local_addr;
    mem_wdata = busy ? ERASED_BYTE : (old_data & wr_data);
  end

  flash_array #(.ARR_W(ARR_W)) u_array (
    .clk      (clk),
    .rst_n    (rst_n),
    .we       (mem_we),
    .waddr    (mem_addr),
    .wdata    (mem_wdata),
    .old_data (old_data),
    .rd_en    (rd_en),
    .rd_addr  (rd_addr),
    .id_mode  (id_mode),
    .dev_code (dev_code),
    .rd_data  (rd_data)
  );

endmodule

// File: rtl/flash_cmd_chk.sv
module flash_cmd_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic [7:0] wr_data,
  input logic       busy,
  input logic [2:0] seq_state,
  input logic       id_mode,
  input logic [1:0] size_sel
);

  assert_busy_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (seq_state == 3'd0));

  assert_busy_ignore_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && wr_en) |=> $stable(id_mode));

  assert_state_legal_R3: assert property (@(posedge clk) disable iff (!rst_n)
    seq_state <= 3'd6);

  assert_prog_return_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !busy && seq_state == 3'd3) |=> (seq_state == 3'd0));

  assert_mismatch_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !busy && seq_state == 3'd1 && wr_data != 8'h55) |=> (seq_state == 3'd0));

  assert_id_entry_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(id_mode) |-> ($past(seq_state) == 3'd2 && $past(wr_data) == 8'h90));

  assert_id_gate_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (size_sel == 2'd0 && !id_mode) |=> !id_mode);

endmodule

bind flash_cmd_emu flash_cmd_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .wr_en     (wr_en),
  .wr_data   (wr_data),
  .busy      (busy),
  .seq_state (seq_state),
  .id_mode   (id_mode),
  .size_sel  (size_sel)
);

// File: tb/flash_cmd_emu_bench.sv
module flash_cmd_emu_bench;

  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 19;
  localparam int ARR_W  = 8;
  localparam int SECT_W = 5;
  localparam int DEPTH  = 1 << ARR_W;
  localparam logic [18:0] A_ADDR = 19'h05555;
  localparam logic [18:0] B_ADDR = 19'h02AAA;

  logic             clk;
  logic             rst_n;
  logic             wr_en;
  logic [ADDR_W-1:0] wr_addr;
  logic [7:0]       wr_data;
  logic             rd_en;
  logic [ARR_W-1:0] rd_addr;
  logic [7:0]       rd_data;
  logic [1:0]       size_sel;
  logic [3:0]       cmd_bank;
  logic             busy;
  logic [2:0]       seq_state;

  int n_total = 0;
  int n_fail  = 0;
  logic [7:0] model [DEPTH];

  flash_cmd_emu #(.ADDR_W(ADDR_W), .ARR_W(ARR_W), .SECT_W(SECT_W)) u_flash_cmd_emu (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .size_sel(size_sel),
    .cmd_bank(cmd_bank), .busy(busy), .seq_state(seq_state)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_total++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_wr(input logic [18:0] a, input logic [7:0] d);
    wr_addr = a; wr_data = d; wr_en = 1'b1;
    @(posedge clk); @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic unlock();
    do_wr(A_ADDR, 8'hAA);
    do_wr(B_ADDR, 8'h55);
  endtask

  task automatic rd_chk(input int a, input logic [7:0] exp, input string req);
    rd_addr = a[ARR_W-1:0]; rd_en = 1'b1;
    @(posedge clk); @(negedge clk);
    rd_en = 1'b0;
    chk(req, {24'h0, rd_data}, {24'h0, exp});
  endtask

  task automatic program_byte(input int a, input logic [7:0] d);
    unlock();
    do_wr(A_ADDR, 8'hA0);
    do_wr({11'h0, a[7:0]}, d);
    model[a] = model[a] & d;
  endtask

  task automatic erase_cmd(input logic [18:0] a, input logic [7:0] d);
    unlock();
    do_wr(A_ADDR, 8'h80);
    unlock();
    do_wr(a, d);
  endtask

  task automatic count_busy(output int n);
    n = 0;
    while (busy) begin n++; @(negedge clk); end
  endtask

  task automatic sweep_all(input string req);
    for (int a = 0; a < DEPTH; a++) rd_chk(a, model[a], req);
  endtask

  task automatic id_enter();
    unlock();
    do_wr(A_ADDR, 8'h90);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_total++; n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("%0d/%0d checks passed", n_total - n_fail, n_total);
    $finish;
  end

  initial begin
    int n;
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    rd_en = 1'b0; rd_addr = '0; size_sel = 2'd1; cmd_bank = 4'h3;
    repeat (3) @(negedge clk);
    // R1 reset values
    chk("R1 state", {29'h0, seq_state}, 0);
    chk("R1 busy", {31'h0, busy}, 0);
    chk("R1 rd_data", {24'h0, rd_data}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 state after release", {29'h0, seq_state}, 0);

    // R7 chip erase with step-by-step state
    unlock();
    do_wr(A_ADDR, 8'h80);
    chk("R3 erase setup step", {29'h0, seq_state}, 4);
    do_wr(A_ADDR, 8'hAA);
    chk("R3 step5", {29'h0, seq_state}, 5);
    do_wr(B_ADDR, 8'h55);
    chk("R3 step6", {29'h0, seq_state}, 6);
    do_wr(A_ADDR, 8'h10);
    count_busy(n);
    chk("R7 busy length", n, DEPTH);
    for (int a = 0; a < DEPTH; a++) model[a] = 8'hFF;
    sweep_all("R7 erased");

    // R4 program every location twice, AND semantics
    unlock();
    chk("R3 after unlock", {29'h0, seq_state}, 2);
    do_wr(A_ADDR, 8'hA0);
    chk("R3 program armed", {29'h0, seq_state}, 3);
    do_wr(19'h0, 8'hFF);
    chk("R4 return idle", {29'h0, seq_state}, 0);
    for (int a = 0; a < DEPTH; a++) program_byte(a, 8'(a * 37 + 11));
    for (int a = 0; a < DEPTH; a++) program_byte(a, 8'(a * 7) ^ 8'hC3);
    sweep_all("R4 and program");

    // R9 read data held
    rd_chk(9, model[9], "R9 read");
    repeat (3) @(negedge clk);
    chk("R9 hold", {24'h0, rd_data}, {24'h0, model[9]});

    // R2 bank matching
    do_wr({4'h3, 15'h5555}, 8'hAA);
    chk("R2 bank A accepted", {29'h0, seq_state}, 1);
    do_wr({4'h3, 15'h2AAA}, 8'h55);
    chk("R2 bank B accepted", {29'h0, seq_state}, 2);
    do_wr(A_ADDR, 8'h00);
    do_wr({4'h5, 15'h5555}, 8'hAA);
    chk("R2 foreign bank rejected", {29'h0, seq_state}, 0);
    do_wr(19'h05556, 8'hAA);
    chk("R2 wrong low bits", {29'h0, seq_state}, 0);

    // R5 mismatches
    do_wr(A_ADDR, 8'hAA);
    do_wr(B_ADDR, 8'h56);
    chk("R5 wrong key", {29'h0, seq_state}, 0);
    unlock();
    do_wr(19'h05554, 8'hA0);
    chk("R5 wrong op addr", {29'h0, seq_state}, 0);
    do_wr(19'h00010, 8'h00);
    rd_chk(16, model[16], "R5 no write");

    // R6 sector erase from mid-sector address
    erase_cmd(19'h00047, 8'h30);
    count_busy(n);
    chk("R6 busy length", n, 1 << SECT_W);
    for (int a = 'h40; a < 'h60; a++) model[a] = 8'hFF;
    sweep_all("R6 sector");

    // R10/R12 overlay
    id_enter();
    rd_chk(0, 8'hBF, "R10 vendor");
    rd_chk(1, 8'hB5, "R11 dev 128");
    rd_chk(2, model[2], "R10 other loc");
    program_byte(0, 8'h0F);
    rd_chk(0, 8'hBF, "R10 overlay during program");
    do_wr(A_ADDR, 8'hAA);
    do_wr(19'h00123, 8'hF0);
    chk("R12 state reset", {29'h0, seq_state}, 0);
    rd_chk(0, 8'hBF, "R12 no exit from step1");
    do_wr(19'h12345, 8'hF0);
    rd_chk(0, model[0], "R12 single F0 exit");
    rd_chk(1, model[1], "R10 preserved");
    id_enter();
    rd_chk(1, 8'hB5, "R10 re-entry");
    unlock();
    do_wr(A_ADDR, 8'hF0);
    rd_chk(0, model[0], "R12 full exit");

    // R11 size selection
    size_sel = 2'd2;
    id_enter();
    rd_chk(1, 8'hB6, "R11 dev 256");
    do_wr(19'h0, 8'hF0);
    size_sel = 2'd3;
    id_enter();
    rd_chk(1, 8'hB7, "R11 dev 512");
    rd_chk(0, 8'hBF, "R11 vendor 512");
    do_wr(19'h0, 8'hF0);
    size_sel = 2'd0;
    id_enter();
    rd_chk(0, model[0], "R11 no id for size0");
    rd_chk(1, model[1], "R11 no id for size0 b");

    // R8 writes ignored while busy
    erase_cmd(A_ADDR, 8'h10);
    chk("R8 busy", {31'h0, busy}, 1);
    unlock();
    do_wr(A_ADDR, 8'hA0);
    do_wr(19'h00005, 8'h00);
    chk("R8 state held idle", {29'h0, seq_state}, 0);
    count_busy(n);
    chk("R8 state after sweep", {29'h0, seq_state}, 0);
    for (int a = 0; a < DEPTH; a++) model[a] = 8'hFF;
    rd_chk(5, 8'hFF, "R8 no program");
    do_wr(19'h00005, 8'h00);
    rd_chk(5, 8'hFF, "R8 no armed program left");

    $display("%0d/%0d checks passed", n_total - n_fail, n_total);
    $finish;
  end

endmodule